// File: doc/BRIEF.md
# CBC Cipher DMA Sequencer

This block moves bytes between a byte-wide memory and a 16-byte block-cipher engine. It has four channels, so a whole chain of CBC-mode encryption can run without a processor. Each channel holds its own settings: a target code that picks the engine path, a wrap bit, a base address, a size and a running offset. These are programmed through a small register write port. A select register picks which channel the shared window registers reach.

A typical run uses the four channels as follows:

- **Key channel.** In wrap mode it re-feeds the key to the engine for every block.
- **Data channel.** It streams plaintext to the engine's data input.
- **XOR channel.** It starts at the chaining vector. When that vector sits immediately before the output buffer, the channel's linear pointer slides onto each freshly written ciphertext block.
- **Result channel.** It drains each finished block back to memory.

Flow control keeps the XOR reads behind the result writes. Fixed priority grants one memory byte per clock. Per-channel done and error flags feed one interrupt line.

Top module: `cbc_dma_seq`

## Requirements
- R1: After reset the done flags, error flags and interrupt are all zero, and there is no memory request and no engine strobe.
- R2: Bit i of the enable register (address 1) enables channel i. The channel starts only when that bit goes from 0 to 1 and its size is valid. The window registers (addresses 4 to 11: config, mode, base low/high, size low/high, offset low/high) act on the channel named by the select register (address 0).
- R3: Config bits [3:0] hold the target code: 5 is key-in, 6 is data-in, 7 is XOR-in and 8 is result-out. A channel with any other code never transfers. Only one engine path is strobed in a cycle.
- R4: With mode bit 0 set (wrap), a channel's offset returns to zero after the byte at offset size-1. The channel sets its done flag and keeps running, so every block receives the whole key.
- R5: With wrap clear, a channel sets its done flag when its offset reaches its size, and then stops.
- R6: A result-out channel moves a byte only while the engine reports a result byte available. That byte is written to memory in the same cycle it is popped.
- R7: An XOR-in channel fetches no byte of block n+1 until the result-out channel has written all 16 bytes of block n. Multi-block CBC, with the vector placed 16 bytes before the output buffer, therefore produces correct chained ciphertext.
- R8: The lowest-numbered ready channel is granted, and at most one memory byte moves per clock.
- R9: The interrupt is high exactly when some done flag is set whose channel has config bit 7 (interrupt enable) set.
- R10: Writing the done register (address 2) or the error register (address 3) clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Without such a write, a flag never clears.
- R11: A start is refused, and the channel's error flag is set, in two cases:
  - the size is zero, on any channel;
  - the size is not a multiple of 16, on a data-in, XOR-in or result-out channel.

  A key-in channel accepts any nonzero size.
- R12: The memory address is the channel's base plus its current offset. Read data is taken in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the request cycle |
| eng_byte | output | 8 | Byte offered to the engine input paths |
| key_vld | output | 1 | Key byte strobe |
| key_rdy | input | 1 | Engine can take a key byte |
| din_vld | output | 1 | Plaintext byte strobe |
| din_rdy | input | 1 | Engine can take a plaintext byte |
| xin_vld | output | 1 | XOR byte strobe |
| xin_rdy | input | 1 | Engine can take an XOR byte |
| res_pop | output | 1 | Result byte consumed |
| res_vld | input | 1 | Engine has a result byte |
| res_byte | input | 8 | Current result byte |
| done_flags | output | NCH | Per-channel completion flags |
| err_flags | output | NCH | Per-channel start-error flags |
| irq | output | 1 | Interrupt |

## Verification
The assertions take the following for granted:
- Software leaves a channel's size, base and offset alone while that channel is running.
- A channel is restarted only after its offset has been cleared.
- The engine raises each ready line only while it can take another byte on that path.

The stimulus respects these limits. It:
- programs every window register, clearing the offset, before raising the enable bits;
- resets the block between CBC runs instead of reprogramming running channels;
- uses an engine stand-in that buffers one block of each input, holds a finished block until all 16 bytes are popped, and accepts the next block's inputs meanwhile.

That last property makes the XOR flow-control rule observable in the ciphertext.

// File: rtl/cbc_dma_pkg.sv
// Shared constants for the CBC cipher DMA sequencer.
// Assumes: register fields are 16 bits wide; cipher blocks are 16 bytes.
package cbc_dma_pkg;
    localparam int REG_W     = 16;
    localparam int BLK_BYTES = 16;
    localparam int BLK_LSB   = $clog2(BLK_BYTES);

    // register addresses
    localparam logic [3:0] RA_SEL    = 4'd0;
    localparam logic [3:0] RA_EN     = 4'd1;
    localparam logic [3:0] RA_DONE   = 4'd2;
    localparam logic [3:0] RA_ERR    = 4'd3;
    localparam logic [3:0] RA_CFG    = 4'd4;
    localparam logic [3:0] RA_MODE   = 4'd5;
    localparam logic [3:0] RA_BASE_L = 4'd6;
    localparam logic [3:0] RA_BASE_H = 4'd7;
    localparam logic [3:0] RA_SIZE_L = 4'd8;
    localparam logic [3:0] RA_SIZE_H = 4'd9;
    localparam logic [3:0] RA_OFS_L  = 4'd10;
    localparam logic [3:0] RA_OFS_H  = 4'd11;

    // target path codes
    localparam logic [3:0] TGT_KEY = 4'h5;
    localparam logic [3:0] TGT_DIN = 4'h6;
    localparam logic [3:0] TGT_XIN = 4'h7;
    localparam logic [3:0] TGT_RES = 4'h8;
endpackage

// File: rtl/cbc_dma_chan.sv
// One DMA channel: holds target code, wrap bit, interrupt enable, base,
// size and offset; steps the offset on each granted byte.
// Assumes: window fields are not rewritten while the channel is active,
// and the offset is cleared before a start.
module cbc_dma_chan
    import cbc_dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_field,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic          step,
    output logic [3:0]    tgt,
    output logic          irq_en,
    output logic [AW-1:0] addr,
    output logic [REG_W-1:0] ofs,
    output logic          active,
    output logic          fin,
    output logic          bad_start
);
    logic [3:0]       tgt_q;
    logic             ie_q;
    logic             wrap_q;
    logic [REG_W-1:0] base_q;
    logic [REG_W-1:0] size_q;
    logic [REG_W-1:0] ofs_q;
    logic             act_q;
    logic             last;
    logic             bad;
    logic [REG_W-1:0] sum;

    // purpose: flag sizes that may not start on this channel's path
    assign bad  = (size_q == '0) ||
                  ((tgt_q != TGT_KEY) && (size_q[BLK_LSB-1:0] != '0));
    // purpose: detect the final byte of the programmed size
    assign last = ((ofs_q + REG_W'(1)) == size_q);
    assign sum  = base_q + ofs_q;

    // purpose: field writes, start acceptance and offset stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            ie_q   <= 1'b0;
            wrap_q <= 1'b0;
            base_q <= '0;
            size_q <= '0;
            ofs_q  <= '0;
            act_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    RA_CFG:    begin tgt_q <= wr_data[3:0]; ie_q <= wr_data[7]; end
                    RA_MODE:   wrap_q <= wr_data[0];
                    RA_BASE_L: base_q[7:0]  <= wr_data;
                    RA_BASE_H: base_q[15:8] <= wr_data;
                    RA_SIZE_L: size_q[7:0]  <= wr_data;
                    RA_SIZE_H: size_q[15:8] <= wr_data;
                    RA_OFS_L:  ofs_q[7:0]   <= wr_data;
                    RA_OFS_H:  ofs_q[15:8]  <= wr_data;
                    default: ;
                endcase
            end
            if (start) act_q <= !bad;
            if (step) begin
                if (last && wrap_q) begin
                    ofs_q <= '0;
                end else begin
                    ofs_q <= ofs_q + REG_W'(1);
                    if (last) act_q <= 1'b0;
                end
            end
        end
    end

    assign tgt       = tgt_q;
    assign irq_en    = ie_q;
    assign addr      = sum[AW-1:0];
    assign ofs       = ofs_q;
    assign active    = act_q;
    assign fin       = step && last;
    assign bad_start = start && bad;

    // R4: a wrapping channel goes back to offset zero after its last byte
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_q && last) |=> (ofs_q == '0));
    // R5: a non-wrapping channel stops after its last byte
    a_r5_stop_at_size: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap_q && last) |=> !act_q);
    // R12: a running channel never addresses past its size
    a_r12_ofs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (ofs_q < size_q));
    // R11: a refused start leaves the channel idle
    a_r11_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bad && !act_q) |=> !act_q);
endmodule

// File: rtl/cbc_dma_arb.sv
// Fixed-priority arbiter: lowest request index wins.
// Assumes: requests are stable within a cycle; one grant per cycle.
module cbc_dma_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx
);
    // purpose: isolate the lowest set request bit
    assign gnt = req & (~req + N'(1));

    // purpose: encode the granted index
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) idx = IW'(i);
        end
    end

    // R8: at most one grant, always to a requester, none skipped below it
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0));
    a_r8_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/cbc_dma_seq.sv
// Four-channel memory/cipher DMA sequencer top. Decodes register writes,
// keeps enable, done and error flags, gates each channel on its engine
// path, and holds XOR reads behind result writes for CBC chaining.
// Assumes: memory read data is valid in the request cycle; NCH <= 8.
module cbc_dma_seq
    import cbc_dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [3:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    output logic [7:0]     eng_byte,
    output logic           key_vld,
    input  logic           key_rdy,
    output logic           din_vld,
    input  logic           din_rdy,
    output logic           xin_vld,
    input  logic           xin_rdy,
    output logic           res_pop,
    input  logic           res_vld,
    input  logic [7:0]     res_byte,
    output logic [NCH-1:0] done_flags,
    output logic [NCH-1:0] err_flags,
    output logic           irq
);
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [SELW-1:0]  sel_q;
    logic [NCH-1:0]   en_q, done_q, err_q;
    logic [NCH-1:0]   start, chan_wr, req, gnt, fin, bad, act, ie, path_rdy;
    logic [3:0]       tgt  [NCH];
    logic [REG_W-1:0] ofs  [NCH];
    logic [AW-1:0]    addr [NCH];
    logic [REG_W-1:0] res_ofs;
    logic [SELW-1:0]  gidx;
    logic             win_wr, any, clr_done, clr_err;
    logic [3:0]       g_tgt;

    assign win_wr   = reg_we && (reg_addr >= RA_CFG) && (reg_addr <= RA_OFS_H);
    assign clr_done = reg_we && (reg_addr == RA_DONE);
    assign clr_err  = reg_we && (reg_addr == RA_ERR);

    // purpose: find how far the result channel has written (lowest wins)
    always_comb begin
        res_ofs = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (tgt[i] == TGT_RES) res_ofs = ofs[i];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic xor_ok;
        // purpose: XOR bytes of a block wait until the previous block is written
        assign xor_ok = (ofs[g] >> BLK_LSB) <= (res_ofs >> BLK_LSB);
        assign start[g]   = reg_we && (reg_addr == RA_EN) && reg_wdata[g] && !en_q[g];
        assign chan_wr[g] = win_wr && (sel_q == SELW'(g));
        assign path_rdy[g] = (tgt[g] == TGT_KEY) ? key_rdy :
                             (tgt[g] == TGT_DIN) ? din_rdy :
                             (tgt[g] == TGT_XIN) ? (xin_rdy && xor_ok) :
                             (tgt[g] == TGT_RES) ? res_vld : 1'b0;
        assign req[g] = en_q[g] && act[g] && path_rdy[g];

        cbc_dma_chan #(.AW(AW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (chan_wr[g]),
            .wr_field  (reg_addr),
            .wr_data   (reg_wdata),
            .start     (start[g]),
            .step      (gnt[g]),
            .tgt       (tgt[g]),
            .irq_en    (ie[g]),
            .addr      (addr[g]),
            .ofs       (ofs[g]),
            .active    (act[g]),
            .fin       (fin[g]),
            .bad_start (bad[g])
        );
    end

    cbc_dma_arb #(.N(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt),
        .idx   (gidx)
    );

    // purpose: select, enable, done and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            en_q   <= '0;
            done_q <= '0;
            err_q  <= '0;
        end else begin
            if (reg_we && (reg_addr == RA_SEL)) sel_q <= reg_wdata[SELW-1:0];
            if (reg_we && (reg_addr == RA_EN))  en_q  <= reg_wdata[NCH-1:0];
            done_q <= (clr_done ? (done_q & reg_wdata[NCH-1:0]) : done_q) | fin;
            err_q  <= (clr_err  ? (err_q  & reg_wdata[NCH-1:0]) : err_q)  | bad;
        end
    end

    // purpose: route the granted channel onto the memory and engine ports
    assign any       = |gnt;
    assign g_tgt     = tgt[gidx];
    assign mem_req   = any;
    assign mem_we    = any && (g_tgt == TGT_RES);
    assign mem_addr  = addr[gidx];
    assign mem_wdata = res_byte;
    assign eng_byte  = mem_rdata;
    assign key_vld   = any && (g_tgt == TGT_KEY);
    assign din_vld   = any && (g_tgt == TGT_DIN);
    assign xin_vld   = any && (g_tgt == TGT_XIN);
    assign res_pop   = mem_we;

    assign done_flags = done_q;
    assign err_flags  = err_q;
    assign irq        = |(done_q & ie);

    // R3: a single engine path is strobed per cycle, only when it is ready
    a_r3_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({key_vld, din_vld, xin_vld, res_pop}));
    a_r3_key_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld |-> key_rdy);
    // R6: a result byte is popped only while the engine offers one
    a_r6_pop_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_pop |-> (res_vld && mem_req && mem_we));
    // R7: XOR fetch stays within the block the result channel has released
    a_r7_xor_behind_result: assert property (@(posedge clk) disable iff (!rst_n)
        xin_vld |-> ((ofs[gidx] >> BLK_LSB) <= (res_ofs >> BLK_LSB)));
    // R10: flags clear only through a write of zero
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_done |=> ((done_q & $past(done_q)) == $past(done_q)));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/cbc_dma_seq_tb_top.sv
`timescale 1ns/1ps
// Stand-in cipher engine: buffers 16 key, data and XOR bytes, produces
// out[i] = (data[i] ^ xor[i]) + key[i], and holds the result until popped
// while already accepting the next block's inputs.
module cbc_eng_stub (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_vld,
    input  logic       din_vld,
    input  logic       xin_vld,
    input  logic [7:0] wbyte,
    input  logic       res_pop,
    output logic       key_rdy,
    output logic       din_rdy,
    output logic       xin_rdy,
    output logic       res_vld,
    output logic [7:0] res_byte
);
    logic [7:0] kb [16];
    logic [7:0] db [16];
    logic [7:0] xb [16];
    logic [7:0] ob [16];
    logic [4:0] kc, dc, xc;
    logic [3:0] oc;
    logic       ov;

    assign key_rdy  = kc < 5'd16;
    assign din_rdy  = dc < 5'd16;
    assign xin_rdy  = xc < 5'd16;
    assign res_vld  = ov;
    assign res_byte = ob[oc];

    always @(posedge clk) begin
        if (!rst_n) begin
            kc <= '0; dc <= '0; xc <= '0; oc <= '0; ov <= 1'b0;
        end else begin
            if (key_vld && key_rdy) begin kb[kc[3:0]] <= wbyte; kc <= kc + 5'd1; end
            if (din_vld && din_rdy) begin db[dc[3:0]] <= wbyte; dc <= dc + 5'd1; end
            if (xin_vld && xin_rdy) begin xb[xc[3:0]] <= wbyte; xc <= xc + 5'd1; end
            if (!ov && kc == 5'd16 && dc == 5'd16 && xc == 5'd16) begin
                for (int i = 0; i < 16; i++) ob[i] <= (db[i] ^ xb[i]) + kb[i];
                ov <= 1'b1; kc <= '0; dc <= '0; xc <= '0;
            end
            if (res_pop && ov) begin
                if (oc == 4'd15) begin ov <= 1'b0; oc <= '0; end
                else oc <= oc + 4'd1;
            end
        end
    end
endmodule

module cbc_dma_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, eng_byte, res_byte;
    logic key_vld, key_rdy, din_vld, din_rdy, xin_vld, xin_rdy, res_pop, res_vld;
    logic [3:0] done_flags, err_flags;
    logic irq;
    logic tb_we = 1'b0;
    logic [7:0] tb_a = '0, tb_d = '0;
    logic [7:0] mem [256];
    logic [7:0] expv [64];
    logic [7:0] prev [16];
    int n_chk = 0, n_fail = 0;

    // stimulus table: {block count, seed}
    localparam logic [15:0] SCN [3] = '{16'h01_3A, 16'h03_C5, 16'h04_71};

    always #10 clk = ~clk;

    cbc_dma_seq #(.NCH(4), .AW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .eng_byte(eng_byte), .key_vld(key_vld), .key_rdy(key_rdy),
        .din_vld(din_vld), .din_rdy(din_rdy), .xin_vld(xin_vld),
        .xin_rdy(xin_rdy), .res_pop(res_pop), .res_vld(res_vld),
        .res_byte(res_byte), .done_flags(done_flags), .err_flags(err_flags),
        .irq(irq)
    );

    cbc_eng_stub eng_i (
        .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .din_vld(din_vld),
        .xin_vld(xin_vld), .wbyte(eng_byte), .res_pop(res_pop),
        .key_rdy(key_rdy), .din_rdy(din_rdy), .xin_rdy(xin_rdy),
        .res_vld(res_vld), .res_byte(res_byte)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else if (tb_we) mem[tb_a] <= tb_d;
    end

    function automatic logic [7:0] key_b(input logic [7:0] s, input int i);
        return 8'(s * 3 + i * 29 + 1);
    endfunction
    function automatic logic [7:0] pt_b(input logic [7:0] s, input int i);
        return 8'(s ^ (i * 13 + 7));
    endfunction
    function automatic logic [7:0] iv_b(input logic [7:0] s, input int i);
        return 8'(s + i * 41 + 90);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic put(input int a, input logic [7:0] d);
        @(negedge clk); tb_we = 1'b1; tb_a = 8'(a); tb_d = d;
        @(posedge clk); #1 tb_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prog(input int ch, input logic [7:0] cfg, input logic [7:0] mode,
                        input int base, input int size, input int ofs);
        wr(4'd0, 8'(ch));
        wr(4'd4, cfg);
        wr(4'd5, mode);
        wr(4'd6, 8'(base));  wr(4'd7, 8'(base >> 8));
        wr(4'd8, 8'(size));  wr(4'd9, 8'(size >> 8));
        wr(4'd10, 8'(ofs));  wr(4'd11, 8'(ofs >> 8));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int nb, waited, bad;
        logic [7:0] sd, c;
        do_reset();
        // R1: reset state
        chk(done_flags == 4'h0, "R1", "done after reset", done_flags, 0);
        chk(err_flags == 4'h0 && !irq, "R1", "err/irq after reset", {err_flags, irq}, 0);
        chk(!mem_req && !key_vld && !res_pop, "R1", "idle after reset", mem_req, 0);

        // table-driven CBC runs
        for (int s = 0; s < 3; s++) begin
            nb = int'(SCN[s][15:8]);
            sd = SCN[s][7:0];
            do_reset();
            for (int i = 0; i < 16; i++) put(8'h10 + i, key_b(sd, i));
            for (int i = 0; i < nb * 16; i++) put(8'h20 + i, pt_b(sd, i));
            for (int i = 0; i < 16; i++) put(8'h60 + i, iv_b(sd, i));
            for (int i = 0; i < nb * 16; i++) put(8'h70 + i, 8'hEE);
            for (int i = 0; i < 16; i++) prev[i] = iv_b(sd, i);
            for (int b = 0; b < nb; b++) begin
                for (int i = 0; i < 16; i++) begin
                    c = 8'((pt_b(sd, b * 16 + i) ^ prev[i]) + key_b(sd, i));
                    expv[b * 16 + i] = c;
                    prev[i] = c;
                end
            end
            prog(0, 8'h05, 8'h01, 8'h10, 16, 0);
            prog(1, 8'h06, 8'h00, 8'h20, nb * 16, 0);
            prog(2, 8'h07, 8'h00, 8'h60, nb * 16, 0);
            prog(3, 8'h88, 8'h00, 8'h70, nb * 16, 0);
            wr(4'd1, 8'h0F);
            // R8 / R12: the key channel wins the first cycle, at its base
            chk(mem_req && key_vld && mem_addr == 16'h0010, "R8", "first grant to lowest channel",
                mem_addr, 16'h10);
            waited = 0;
            while (!done_flags[3] && waited < 5000) begin @(negedge clk); waited++; end
            chk(waited < 5000, "R6", "result channel completes", waited, 0);
            for (int b = 0; b < nb; b++) begin
                bad = 0;
                for (int i = 0; i < 16; i++)
                    if (mem[8'(8'h70 + b * 16 + i)] != expv[b * 16 + i]) bad++;
                // R7 chained ciphertext; R4 key re-fed per block
                chk(bad == 0, (b == 0) ? "R3" : "R7", "ciphertext block mismatches", bad, 0);
            end
            chk(done_flags == 4'hF, "R5", "all done flags incl. wrapped key (R4)", done_flags, 4'hF);
            chk(irq == 1'b1, "R9", "irq from channel 3 enable", irq, 1);
            chk(err_flags == 4'h0, "R11", "no error on valid sizes", err_flags, 0);
        end

        // R10 / R9: clear only channel 3's done flag by writing zero there
        wr(4'd2, 8'h07);
        chk(done_flags == 4'h7, "R10", "done after partial clear", done_flags, 4'h7);
        chk(irq == 1'b0, "R9", "irq after enabled flag cleared", irq, 0);
        wr(4'd2, 8'h00);
        chk(done_flags == 4'h0, "R10", "done after full clear", done_flags, 0);

        // R11 / R3 / R6: refused starts, unknown code, result without engine data
        do_reset();
        prog(0, 8'h05, 8'h01, 8'h10, 0, 0);
        prog(1, 8'h06, 8'h00, 8'h20, 20, 0);
        prog(2, 8'h08, 8'h00, 8'h70, 16, 0);
        prog(3, 8'h03, 8'h00, 8'h40, 16, 0);
        wr(4'd1, 8'h0F);
        chk(err_flags == 4'h3, "R11", "error flags for bad sizes", err_flags, 4'h3);
        bad = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) bad++; end
        chk(bad == 0, "R6", "no traffic: refused, unknown code (R3), no result", bad, 0);
        chk(done_flags == 4'h0, "R3", "no done from idle channels", done_flags, 0);
        wr(4'd3, 8'h02);
        chk(err_flags == 4'h2, "R10", "error flags after clear-by-zero", err_flags, 4'h2);

        // R12 / R2 / R11: key channel with odd size starts at base + offset
        do_reset();
        prog(0, 8'h05, 8'h01, 8'h30, 20, 2);
        wr(4'd1, 8'h01);
        chk(mem_req && key_vld && mem_addr == 16'h0032, "R12", "address base+offset",
            mem_addr, 16'h32);
        chk(err_flags == 4'h0, "R11", "key channel accepts size 20", err_flags, 0);
        wr(4'd1, 8'h00);
        wr(4'd1, 8'h00);
        chk(!mem_req, "R2", "disabled channel idle", mem_req, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule